// File: doc/BRIEF.md
# Tuner Configuration Register File with Two-Wire Slave Port

This block holds the configuration bytes of a broadcast tuner and lets a host reach them over a standard I2C bus. It oversamples the bus clock and data lines with the system clock. It recognises start, repeated start and stop conditions and answers one 7-bit device address. One bit of that address comes from a strap input, so two tuners can share a bus.

A write sets an internal byte pointer and then stores any number of data bytes, with the pointer moving forward after each byte. A read reuses the pointer set by an earlier write and streams bytes out most significant bit first until the host withholds its acknowledge. Sixteen bytes can be read and written and drive the configuration outputs. Three more bytes are read-only status: they come from the `ro_data_i` input, plus a sticky flag that marks a reset the host has not yet acknowledged. The host clears that flag by reading a specific register. The bus data line is open drain: the block only ever asks for it to be pulled low.

Top module: `tuner_i2c_regfile`

## Requirements
- R1: The device answers address 7'b1100_0A0, where A is `addr_strap_i`, giving write bytes 0xC0 or 0xC4. Any other address is not acknowledged, and the block then leaves the bus and every register untouched until the next start or stop.
- R2: In a write, the first byte after the address is taken as the pointer (low 5 bits). Each following byte is acknowledged and stored at the pointer, which then advances.
- R3: After a repeated start with the read bit set, the slave sends the byte at the pointer MSB first and advances the pointer. A host acknowledge makes it send the next byte. A host not-acknowledge makes it release the data line and stay quiet.
- R4: A start is data falling while the clock is high, and a stop is data rising while the clock is high. A stop returns the block to idle and drops any byte not yet complete. A start, repeated or not, always begins a new address byte.
- R5: Pointers 0x10, 0x11 and 0x12 read `ro_data_i[7:0]`, `[15:8]` and `[23:16]`. Writes to them are acknowledged but discarded. Pointers 0x13 to 0x1F read 0x00.
- R6: Advancing the pointer from 0x12 gives 0x00, for reads and writes alike.
- R7: After reset, register n sits on `cfg_regs_o[8n+7:8n]` and holds 0x17 (0x00), 0x18 (0x01), 0xDB (0x04), 0x7C (0x05), 0x0A (0x06), 0x08 (0x07), 0xC0 (0x09), 0x87 (0x0A), 0x40 (0x0B), and 0x00 for every other index.
- R8: Bit 7 of the byte read at 0x11 is a power-on flag in place of `ro_data_i[15]`. It is 1 after reset, clears once the eighth data bit of a byte read from 0x0C has been sent, and never sets again before the next reset.
- R9: `sda_oe_o` is asserted only while the bus clock is low: in the ninth clock of an acknowledged byte, or for a 0 bit being sent. It is low in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap_i | input | 1 | Strapped device address bit |
| ro_data_i | input | 24 | Status bytes for pointers 0x10 to 0x12 |
| sda_oe_o | output | 1 | Pull the data line low when 1 |
| cfg_regs_o | output | 128 | The sixteen configuration bytes, index 0 in the low byte |

## Verification
Single-byte writes with read-back at several pointers tell apart storage, the pointer byte and the read path. Reads of untouched indices separate the reset values from the written ones. Writes to the status indices, and reads from unused indices, show whether read-only decode and out-of-range decode are confused. Bursts that start at 0x11 and 0x12 expose the wrap point. A wrong address and a stop in mid-byte show whether any state leaks past an ignored or dropped transfer. Reading 0x11 before and after a read of 0x0C, including a read of 0x11 itself, checks that only the specific address clears the flag.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;

  localparam int unsigned REG_W    = 8;
  localparam int unsigned NUM_RW   = 16;
  localparam int unsigned NUM_RO   = 3;
  localparam int unsigned PTR_W    = 5;
  localparam int unsigned LAST_IDX = NUM_RW + NUM_RO - 1;
  localparam int unsigned POR_IDX  = 17;
  localparam int unsigned POR_BIT  = 7;
  localparam int unsigned CLR_IDX  = 12;
  localparam logic [4:0]  ADDR_HI  = 5'b11000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } bus_state_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_PTR,
    BK_DATA
  } byte_kind_e;

  function automatic logic [REG_W-1:0] reg_default(input int unsigned idx);
    case (idx)
      0:       return 8'h17;
      1:       return 8'h18;
      4:       return 8'hDB;
      5:       return 8'h7C;
      6:       return 8'h0A;
      7:       return 8'h08;
      9:       return 8'hC0;
      10:      return 8'h87;
      11:      return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int unsigned NUM_LINES = 2;

  logic [NUM_LINES-1:0]   line_in;
  logic [SYNC_STAGES-1:0] chain_q [NUM_LINES];
  logic [NUM_LINES-1:0]   cur;
  logic [NUM_LINES-1:0]   prev_q;

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q[g] <= '1;
      end else begin
        chain_q[g] <= {chain_q[g][SYNC_STAGES-2:0], line_in[g]};
      end
    end
    assign cur[g] = chain_q[g][SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
    end else begin
      prev_q <= cur;
    end
  end

  assign scl_s     = cur[0];
  assign sda_s     = cur[1];
  assign scl_rise  = cur[0] & ~prev_q[0];
  assign scl_fall  = ~cur[0] & prev_q[0];
  assign start_det = cur[0] & prev_q[0] & prev_q[1] & ~cur[1];
  assign stop_det  = cur[0] & prev_q[0] & ~prev_q[1] & cur[1];

endmodule

// File: rtl/tuner_reg_bank.sv
module tuner_reg_bank
  import tuner_i2c_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [PTR_W-1:0]         wr_idx,
  input  logic [REG_W-1:0]         wr_data,
  input  logic [PTR_W-1:0]         rd_idx,
  input  logic [NUM_RO*REG_W-1:0]  ro_data_i,
  input  logic                     por_clr,
  output logic [REG_W-1:0]         rd_data,
  output logic [NUM_RW*REG_W-1:0]  regs_o,
  output logic                     por_o
);

  logic por_q;
  logic por_d;

  for (genvar i = 0; i < NUM_RW; i++) begin : g_reg
    logic             hit;
    logic [REG_W-1:0] q;
    assign hit = wr_en && (wr_idx == PTR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= reg_default(i);
      end else if (hit) begin
        q <= wr_data;
      end
    end
    assign regs_o[i*REG_W +: REG_W] = q;
  end

  assign por_d = por_q & ~por_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_q <= 1'b1;
    end else begin
      por_q <= por_d;
    end
  end

  assign por_o = por_q;

  always_comb begin
    rd_data = '0;
    if (rd_idx < PTR_W'(NUM_RW)) begin
      rd_data = regs_o[int'(rd_idx)*REG_W +: REG_W];
    end else if (rd_idx <= PTR_W'(LAST_IDX)) begin
      rd_data = ro_data_i[(int'(rd_idx) - NUM_RW)*REG_W +: REG_W];
      if (rd_idx == PTR_W'(POR_IDX)) begin
        rd_data[POR_BIT] = por_q;
      end
    end
  end

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import tuner_i2c_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr_strap,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda_s,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [REG_W-1:0]   rd_data,
  output logic               wr_en,
  output logic [REG_W-1:0]   wr_data,
  output logic [PTR_W-1:0]   ptr_o,
  output logic               por_clr,
  output logic               sda_oe,
  output bus_state_e         state_o
);

  localparam int unsigned CNT_W = $clog2(REG_W + 1);

  bus_state_e         state_q, state_d;
  byte_kind_e         kind_q,  kind_d;
  logic [CNT_W-1:0]   cnt_q,   cnt_d;
  logic [REG_W-1:0]   shift_q, shift_d;
  logic [PTR_W-1:0]   ptr_q,   ptr_d;
  logic               rnw_q,   rnw_d;
  logic               ack_q,   ack_d;
  logic               oe_q,    oe_d;
  logic [6:0]         own_addr;
  logic [PTR_W-1:0]   ptr_next;

  assign own_addr = {ADDR_HI, addr_strap, 1'b0};
  assign ptr_next = (ptr_q == PTR_W'(LAST_IDX)) ? '0 : ptr_q + 1'b1;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    ptr_d   = ptr_q;
    rnw_d   = rnw_q;
    ack_d   = ack_q;
    oe_d    = oe_q;
    wr_en   = 1'b0;
    por_clr = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_RX;
      kind_d  = BK_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise && cnt_q < CNT_W'(REG_W)) begin
            shift_d = {shift_q[REG_W-2:0], sda_s};
            cnt_d   = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_W'(REG_W)) begin
            cnt_d = '0;
            case (kind_q)
              BK_ADDR: begin
                if (shift_q[7:1] == own_addr) begin
                  rnw_d   = shift_q[0];
                  oe_d    = 1'b1;
                  state_d = ST_RX_ACK;
                end else begin
                  state_d = ST_IGNORE;
                end
              end
              BK_PTR: begin
                ptr_d   = shift_q[PTR_W-1:0];
                oe_d    = 1'b1;
                state_d = ST_RX_ACK;
              end
              default: begin
                wr_en   = 1'b1;
                ptr_d   = ptr_next;
                oe_d    = 1'b1;
                state_d = ST_RX_ACK;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            if (kind_q == BK_ADDR && rnw_q) begin
              state_d = ST_TX;
              shift_d = rd_data;
              oe_d    = ~rd_data[REG_W-1];
              cnt_d   = '0;
            end else begin
              state_d = ST_RX;
              oe_d    = 1'b0;
              kind_d  = (kind_q == BK_ADDR) ? BK_PTR : BK_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_W'(REG_W - 1)) begin
              state_d = ST_TX_ACK;
              oe_d    = 1'b0;
              cnt_d   = '0;
              ptr_d   = ptr_next;
              por_clr = (ptr_q == PTR_W'(CLR_IDX));
            end else begin
              shift_d = {shift_q[REG_W-2:0], 1'b0};
              oe_d    = ~shift_q[REG_W-2];
              cnt_d   = cnt_q + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            ack_d = ~sda_s;
          end else if (scl_fall) begin
            if (ack_q) begin
              state_d = ST_TX;
              shift_d = rd_data;
              oe_d    = ~rd_data[REG_W-1];
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= BK_ADDR;
      cnt_q   <= '0;
      shift_q <= '0;
      ptr_q   <= '0;
      rnw_q   <= 1'b0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      ptr_q   <= ptr_d;
      rnw_q   <= rnw_d;
      ack_q   <= ack_d;
      oe_q    <= oe_d;
    end
  end

  assign wr_data = shift_q;
  assign ptr_o   = ptr_q;
  assign sda_oe  = oe_q;
  assign state_o = state_q;

endmodule

// File: rtl/tuner_i2c_regfile.sv
module tuner_i2c_regfile
  import tuner_i2c_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  input  logic                     addr_strap_i,
  input  logic [NUM_RO*REG_W-1:0]  ro_data_i,
  output logic                     sda_oe_o,
  output logic [NUM_RW*REG_W-1:0]  cfg_regs_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en, por_clr, por_flag;
  logic [REG_W-1:0]  wr_data, rd_data;
  logic [PTR_W-1:0]  ptr;
  bus_state_e        bus_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_slave_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .addr_strap (addr_strap_i),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .sda_s      (sda_s),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .rd_data    (rd_data),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .ptr_o      (ptr),
    .por_clr    (por_clr),
    .sda_oe     (sda_oe_o),
    .state_o    (bus_state)
  );

  tuner_reg_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_en),
    .wr_idx    (ptr),
    .wr_data   (wr_data),
    .rd_idx    (ptr),
    .ro_data_i (ro_data_i),
    .por_clr   (por_clr),
    .rd_data   (rd_data),
    .regs_o    (cfg_regs_o),
    .por_o     (por_flag)
  );

endmodule

// File: rtl/tuner_i2c_regfile_chk.sv
module tuner_i2c_regfile_chk
  import tuner_i2c_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     scl_s,
  input logic                     stop_det,
  input logic                     sda_oe_o,
  input logic                     por_flag,
  input logic [NUM_RW*REG_W-1:0]  cfg_regs_o,
  input bus_state_e               bus_state
);

  // R9: the pull-down only starts while the synchronized clock is low
  p_oe_rise_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> (!scl_s && !$past(scl_s)));

  // R1: an ignored transfer never drives the bus
  p_ignore_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == ST_IGNORE) |-> !sda_oe_o);

  // R4: a stop always lands in idle
  p_stop_to_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (bus_state == ST_IDLE));

  // R4: nothing is written while the bus is idle
  p_idle_cfg_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == ST_IDLE) |=> $stable(cfg_regs_o));

  // R8: the power-on flag never comes back after reset
  p_por_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(por_flag));

  // R9: idle leaves the data line released
  p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == ST_IDLE) |-> !sda_oe_o);

endmodule

bind tuner_i2c_regfile tuner_i2c_regfile_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .scl_s      (scl_s),
  .stop_det   (stop_det),
  .sda_oe_o   (sda_oe_o),
  .por_flag   (por_flag),
  .cfg_regs_o (cfg_regs_o),
  .bus_state  (bus_state)
);

// File: tb/tuner_i2c_regfile_test.sv
module tuner_i2c_regfile_test;

  localparam int QTR = 8;

  logic         clk;
  logic         rst_n;
  logic         scl_m;
  logic         sda_m;
  logic         strap;
  logic [23:0]  ro_data;
  logic         sda_oe;
  logic [127:0] cfg;
  logic         sda_line;

  int total_checks = 0;
  int fail_count   = 0;

  assign sda_line = sda_m & ~sda_oe;

  tuner_i2c_regfile uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_line),
    .addr_strap_i (strap),
    .ro_data_i    (ro_data),
    .sda_oe_o     (sda_oe),
    .cfg_regs_o   (cfg)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {is_write, pointer, write data, expected read}
  localparam logic [24:0] VEC [10] = '{
    {1'b0, 8'h00, 8'h00, 8'h17},
    {1'b0, 8'h04, 8'h00, 8'hDB},
    {1'b0, 8'h0A, 8'h00, 8'h87},
    {1'b0, 8'h0B, 8'h00, 8'h40},
    {1'b0, 8'h08, 8'h00, 8'h00},
    {1'b1, 8'h02, 8'hA5, 8'hA5},
    {1'b1, 8'h0F, 8'h3C, 8'h3C},
    {1'b1, 8'h10, 8'hFF, 8'h96},
    {1'b1, 8'h12, 8'h00, 8'h5A},
    {1'b0, 8'h15, 8'h00, 8'h00}
  };

  function automatic logic [127:0] default_image();
    logic [127:0] v = '0;
    v[7:0]     = 8'h17;
    v[15:8]    = 8'h18;
    v[39:32]   = 8'hDB;
    v[47:40]   = 8'h7C;
    v[55:48]   = 8'h0A;
    v[63:56]   = 8'h08;
    v[79:72]   = 8'hC0;
    v[87:80]   = 8'h87;
    v[95:88]   = 8'h40;
    return v;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total_checks++;
    if (act !== exp) begin
      fail_count++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    b = sda_line; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic put_byte(input logic [7:0] d, output logic acked);
    logic nb;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(nb);
    acked = ~nb;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      get_bit(b);
      d = {d[6:0], b};
    end
    put_bit(~give_ack);
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {5'b11000, strap, 1'b0, rd};
  endfunction

  task automatic wr1(input logic [7:0] ptr, input logic [7:0] d, output logic all_ack);
    logic a0, a1, a2;
    bus_start();
    put_byte(dev(1'b0), a0);
    put_byte(ptr, a1);
    put_byte(d, a2);
    bus_stop();
    all_ack = a0 & a1 & a2;
  endtask

  task automatic rd_setup(input logic [7:0] ptr);
    logic a;
    bus_start();
    put_byte(dev(1'b0), a);
    put_byte(ptr, a);
    bus_start();
    put_byte(dev(1'b1), a);
  endtask

  task automatic rd1(input logic [7:0] ptr, output logic [7:0] d);
    rd_setup(ptr);
    get_byte(d, 1'b0);
    bus_stop();
  endtask

  initial begin
    logic [7:0] rb, rb2, rb3;
    logic       ok, a;
    scl_m   = 1'b1;
    sda_m   = 1'b1;
    strap   = 1'b0;
    ro_data = 24'h5A_3C_96;
    rst_n   = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    check("R7 reset image", cfg, default_image());
    check("R9 idle release", 128'(sda_oe), 128'(1'b0));

    for (int v = 0; v < 10; v++) begin
      logic [24:0] e;
      e = VEC[v];
      if (e[24]) begin
        wr1(e[23:16], e[15:8], ok);
        check(e[23:16] >= 8'h10 ? "R5 ro write acked" : "R2 write acked", 128'(ok), 128'(1'b1));
      end
      rd1(e[23:16], rb);
      if (e[23:16] >= 8'h10)      check("R5 ro read", 128'(rb), 128'(e[7:0]));
      else if (e[24])             check("R2 readback", 128'(rb), 128'(e[7:0]));
      else                        check("R3 R7 default read", 128'(rb), 128'(e[7:0]));
    end
    check("R2 port image 0x02", 128'(cfg[23:16]), 128'(8'hA5));

    // R6: burst write from 0x11 wraps to 0x00 and 0x01
    bus_start();
    put_byte(dev(1'b0), a);
    put_byte(8'h11, a);
    put_byte(8'hD0, a);
    put_byte(8'hD1, a);
    put_byte(8'hD2, a);
    put_byte(8'hD3, ok);
    bus_stop();
    check("R6 wrap write 0x00", 128'(cfg[7:0]), 128'(8'hD2));
    check("R6 wrap write 0x01 ack", 128'({cfg[15:8], ok}), 128'({8'hD3, 1'b1}));

    // R3: burst read with ack, ack, nack
    rd_setup(8'h04);
    get_byte(rb, 1'b1);
    get_byte(rb2, 1'b1);
    get_byte(rb3, 1'b0);
    check("R3 burst released after nack", 128'(sda_oe), 128'(1'b0));
    bus_stop();
    check("R3 burst read", 128'({rb, rb2, rb3}), 128'(24'hDB7C0A));

    // R6: burst read wrapping 0x12 -> 0x00
    rd_setup(8'h12);
    get_byte(rb, 1'b1);
    get_byte(rb2, 1'b0);
    bus_stop();
    check("R6 wrap read", 128'({rb, rb2}), 128'(16'h5AD2));

    // R8: flag set, survives read of 0x11, clears after read of 0x0C
    rd1(8'h11, rb);
    check("R8 flag set after reset", 128'(rb), 128'(8'hBC));
    rd1(8'h11, rb);
    check("R8 flag kept by other reads", 128'(rb), 128'(8'hBC));
    rd1(8'h0C, rb);
    rd1(8'h11, rb);
    check("R8 flag cleared by 0x0C read", 128'(rb), 128'(8'h3C));

    // R1: wrong address is not acknowledged and has no effect
    bus_start();
    put_byte(8'hC4, ok);
    check("R1 mismatch nack", 128'(ok), 128'(1'b0));
    put_byte(8'h03, ok);
    put_byte(8'h77, a);
    bus_stop();
    check("R1 ignored bytes nack", 128'({ok, a}), 128'(2'b00));
    check("R1 ignored write", 128'(cfg[31:24]), 128'(8'h00));

    // R1: strap moves the address
    strap = 1'b1;
    wr1(8'h03, 8'h66, ok);
    check("R1 strapped write", 128'({cfg[31:24], ok}), 128'({8'h66, 1'b1}));
    strap = 1'b0;

    // R4: stop in mid data byte drops it, new transfer still works
    bus_start();
    put_byte(dev(1'b0), a);
    put_byte(8'h07, a);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    check("R4 partial byte dropped", 128'(cfg[63:56]), 128'(8'h08));
    wr1(8'h07, 8'h19, ok);
    check("R4 restart after abort", 128'({cfg[63:56], ok}), 128'({8'h19, 1'b1}));
    check("R9 released after stop", 128'(sda_oe), 128'(1'b0));

    $display("End of test - %0d assertions evaluated, %0d failures", total_checks, fail_count);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    fail_count++;
    $display("FAIL watchdog expired actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", total_checks, fail_count);
    $finish;
  end

endmodule